// File: doc/BRIEF.md
# Edge-Selectable Sticky Interrupt Status Field

This block is one interrupt status field of a register. A hardware trigger vector is turned into status bits. A capture mode picks what counts as an event: the trigger level, its rising edge, its falling edge, or either edge. A hold mode picks what an event does:
- In per-bit holding, each status bit is set on its own event and stays set.
- In whole-field holding, an event on any bit loads the complete trigger value into the field.
- In follow mode, the status is simply a registered copy of the trigger.

Software clears held bits by writing ones (write-one-to-clear). The field drives two qualified copies of its status. The interrupt copy is formed from a mask or an enable vector, and the halt copy from a second mask or enable vector. Each copy also has a reduced OR, which a register-level interrupt line uses. Whether each qualifier acts as a mask, an enable or nothing is chosen by parameter.

Top module: `intr_status_field`

## Requirements
- R1: While `rst_n` is low, `status_o`, `irq_o`, `halt_o`, `irq_any_o` and `halt_any_o` are all zero. Reset is asynchronous and active-low.
- R2: With `hold_mode_i` = 0 (follow), `status_o` equals the `trig_i` value sampled at the previous clock edge, for any capture mode. A clear write has no effect in this mode.
- R3: With `cap_mode_i` = 0 (level) and per-bit holding (`hold_mode_i` = 1), a status bit is set after any edge at which its trigger bit is 1. The bit stays set after the trigger returns to 0.
- R4: With `cap_mode_i` = 1 (rising), a bit's event occurs only when the trigger bit is 1 now and was 0 at the previous clock edge. A trigger bit that falls or stays constant causes no event.
- R5: With `cap_mode_i` = 2 (falling), a bit's event occurs only when the trigger bit is 0 now and was 1 at the previous clock edge.
- R6: With `cap_mode_i` = 3 (both), a bit's event occurs whenever the trigger bit differs from its value at the previous clock edge.
- R7: In per-bit holding, an event on one bit sets only that status bit. All other status bits keep their values.
- R8: With `hold_mode_i` = 2 (whole-field), an event on any bit loads the entire current `trig_i` into `status_o`, including zeros. Without an event the field holds its value.
- R9: In the holding modes (1 and 2), a cycle with `clr_we_i` high clears every status bit whose `clr_data_i` bit is 1. Bits written with 0 are kept.
- R10: If a bit is being cleared in the same cycle that an event occurs, the event wins. In per-bit mode the bit ends up set. In whole-field mode the trigger value is loaded.
- R11: With the default interrupt qualifier (mask), `irq_o` = `status_o` AND NOT `mask_i`, combinationally.
- R12: With the default halt qualifier (enable), `halt_o` = `status_o` AND `halt_qual_i`, combinationally.
- R13: `irq_any_o` is the OR of all `irq_o` bits, and `halt_any_o` is the OR of all `halt_o` bits.
- R14: The stored previous-trigger value resets to 0. As a result, a trigger bit that is already high when reset is released counts as a rising edge at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_mode_i | input | 2 | Capture mode: 0 level, 1 rising, 2 falling, 3 both |
| hold_mode_i | input | 2 | Hold mode: 0 follow, 1 per-bit, 2 whole-field, 3 treated as follow |
| trig_i | input | WIDTH | Hardware trigger vector |
| clr_we_i | input | 1 | Software write strobe for clearing |
| clr_data_i | input | WIDTH | Write data; ones clear status bits |
| mask_i | input | WIDTH | Interrupt qualifier vector |
| halt_qual_i | input | WIDTH | Halt qualifier vector |
| status_o | output | WIDTH | Status field |
| irq_o | output | WIDTH | Qualified interrupt bits |
| halt_o | output | WIDTH | Qualified halt bits |
| irq_any_o | output | 1 | OR of the qualified interrupt bits |
| halt_any_o | output | 1 | OR of the qualified halt bits |

## Verification
The trigger is driven through sequences that produce one kind of transition at a time: a rise, a fall, a steady high level and a return to zero. Each capture mode must then react to exactly the transition it selects and ignore the others. Running the same sequences under per-bit and whole-field holding separates the two modes: a rise on a second bit either adds one bit to the status or replaces the whole field. Clear writes are issued once alone, once with data that covers only some of the bits, and once in the same cycle as a new event, which shows the priority between clear and event. The qualifier vectors are changed while the status is held steady, so that the mask and enable formulas and their OR outputs are each seen independently of capture.

// File: rtl/intr_field_pkg.sv
package intr_field_pkg;

  typedef enum logic [1:0] {
    CAP_LEVEL = 2'd0,
    CAP_RISE  = 2'd1,
    CAP_FALL  = 2'd2,
    CAP_BOTH  = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    HOLD_FOLLOW = 2'd0,
    HOLD_PER_BIT = 2'd1,
    HOLD_WHOLE  = 2'd2,
    HOLD_RSVD   = 2'd3
  } hold_mode_e;

  typedef enum logic [1:0] {
    QUAL_NONE   = 2'd0,
    QUAL_MASK   = 2'd1,
    QUAL_ENABLE = 2'd2
  } qual_kind_e;

endpackage

// File: rtl/intr_edge_detect.sv
module intr_edge_detect
  import intr_field_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cap_mode_e        mode_i,
  input  logic [WIDTH-1:0] trig_i,
  output logic [WIDTH-1:0] ev_o
);

  logic [WIDTH-1:0] trig_q;

  // previous trigger value, cleared by the field reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trig_i;
  end

  function automatic logic [WIDTH-1:0] pick_events(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] prev,
    input cap_mode_e        mode
  );
    case (mode)
      CAP_RISE: return cur & ~prev;
      CAP_FALL: return ~cur & prev;
      CAP_BOTH: return cur ^ prev;
      default:  return cur;
    endcase
  endfunction

  assign ev_o = pick_events(trig_i, trig_q, mode_i);

  // a rising event never appears on a bit that is low now
  assert_rise_needs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CAP_RISE) |-> ((ev_o & ~trig_i) == '0));

  // a falling event never appears on a bit that is high now
  assert_fall_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CAP_FALL) |-> ((ev_o & trig_i) == '0));

endmodule

// File: rtl/intr_status_latch.sv
module intr_status_latch
  import intr_field_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hold_mode_e       mode_i,
  input  logic [WIDTH-1:0] trig_i,
  input  logic [WIDTH-1:0] ev_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] status_o,
  output logic             field_hit_o
);

  logic [WIDTH-1:0] clr_vec;
  logic [WIDTH-1:0] status_d;

  assign clr_vec     = clr_we_i ? clr_data_i : '0;
  assign field_hit_o = |ev_i;

  function automatic logic [WIDTH-1:0] next_status(
    input hold_mode_e       mode,
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] trig,
    input logic [WIDTH-1:0] ev,
    input logic [WIDTH-1:0] clr,
    input logic             hit
  );
    case (mode)
      HOLD_PER_BIT: return (cur & ~clr) | ev;
      HOLD_WHOLE:   return hit ? trig : (cur & ~clr);
      default:      return trig;
    endcase
  endfunction

  assign status_d = next_status(mode_i, status_o, trig_i, ev_i, clr_vec, field_hit_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= status_d;
  end

  assert_follow_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HOLD_FOLLOW) |=> (status_o == $past(trig_i)));

  assert_event_sets_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HOLD_PER_BIT) |=> ((status_o & $past(ev_i)) == $past(ev_i)));

  assert_whole_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HOLD_WHOLE && field_hit_o) |=> (status_o == $past(trig_i)));

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HOLD_PER_BIT && clr_we_i)
      |=> ((status_o & $past(clr_data_i & ~ev_i)) == '0));

  assert_event_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == HOLD_PER_BIT && clr_we_i && ((clr_data_i & ev_i) != '0))
      |=> ((status_o & $past(clr_data_i & ev_i)) != '0));

endmodule

// File: rtl/intr_qualify.sv
module intr_qualify
  import intr_field_pkg::*;
#(
  parameter int         WIDTH = 4,
  parameter qual_kind_e KIND  = QUAL_MASK
) (
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] qual_i,
  output logic [WIDTH-1:0] out_o,
  output logic             any_o
);

  generate
    if (KIND == QUAL_MASK) begin : g_mask
      assign out_o = status_i & ~qual_i;
    end else if (KIND == QUAL_ENABLE) begin : g_enable
      assign out_o = status_i & qual_i;
    end else begin : g_raw
      logic [WIDTH-1:0] unused_qual;
      assign unused_qual = qual_i;
      assign out_o = status_i;
    end
  endgenerate

  assign any_o = |out_o;

endmodule

// File: rtl/intr_status_field.sv
module intr_status_field
  import intr_field_pkg::*;
#(
  parameter int         WIDTH     = 4,
  parameter qual_kind_e IRQ_QUAL  = QUAL_MASK,
  parameter qual_kind_e HALT_QUAL = QUAL_ENABLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cap_mode_i,
  input  logic [1:0]       hold_mode_i,
  input  logic [WIDTH-1:0] trig_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_data_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] halt_qual_i,
  output logic [WIDTH-1:0] status_o,
  output logic [WIDTH-1:0] irq_o,
  output logic [WIDTH-1:0] halt_o,
  output logic             irq_any_o,
  output logic             halt_any_o
);

  cap_mode_e        cap_mode;
  hold_mode_e       hold_mode;
  logic [WIDTH-1:0] trig_event;
  logic             field_hit;

  assign cap_mode  = cap_mode_e'(cap_mode_i);
  assign hold_mode = hold_mode_e'(hold_mode_i);

  intr_edge_detect #(.WIDTH(WIDTH)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (cap_mode),
    .trig_i (trig_i),
    .ev_o   (trig_event)
  );

  intr_status_latch #(.WIDTH(WIDTH)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (hold_mode),
    .trig_i      (trig_i),
    .ev_i        (trig_event),
    .clr_we_i    (clr_we_i),
    .clr_data_i  (clr_data_i),
    .status_o    (status_o),
    .field_hit_o (field_hit)
  );

  intr_qualify #(.WIDTH(WIDTH), .KIND(IRQ_QUAL)) u_irq_qual (
    .status_i (status_o),
    .qual_i   (mask_i),
    .out_o    (irq_o),
    .any_o    (irq_any_o)
  );

  intr_qualify #(.WIDTH(WIDTH), .KIND(HALT_QUAL)) u_halt_qual (
    .status_i (status_o),
    .qual_i   (halt_qual_i),
    .out_o    (halt_o),
    .any_o    (halt_any_o)
  );

  assert_irq_within_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~status_o) == '0));

  assert_halt_within_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_o & ~status_o) == '0));

  assert_any_tracks_bits_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_any_o == (irq_o != '0)) && (halt_any_o == (halt_o != '0)));

  assert_whole_hit_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode == HOLD_WHOLE && field_hit) |=> (status_o == $past(trig_i)));

endmodule

// File: tb/intr_status_field_bench.sv
`timescale 1ns/1ps
module intr_status_field_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cap_mode_i = 2'd1;
  logic [1:0]   hold_mode_i = 2'd1;
  logic [W-1:0] trig_i = '0;
  logic         clr_we_i = 1'b0;
  logic [W-1:0] clr_data_i = '0;
  logic [W-1:0] mask_i = '0;
  logic [W-1:0] halt_qual_i = '0;
  logic [W-1:0] status_o, irq_o, halt_o;
  logic         irq_any_o, halt_any_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_status_field u_intr_status_field (
    .clk(clk), .rst_n(rst_n), .cap_mode_i(cap_mode_i), .hold_mode_i(hold_mode_i),
    .trig_i(trig_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .mask_i(mask_i), .halt_qual_i(halt_qual_i), .status_o(status_o),
    .irq_o(irq_o), .halt_o(halt_o), .irq_any_o(irq_any_o), .halt_any_o(halt_any_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // apply inputs at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic [W-1:0] trig, input logic we, input logic [W-1:0] data);
    trig_i = trig; clr_we_i = we; clr_data_i = data;
    @(negedge clk);
    clr_we_i = 1'b0; clr_data_i = '0;
  endtask

  task automatic t_reset;
    cap_mode_i = 2'd1; hold_mode_i = 2'd1; trig_i = 4'b0001;
    @(negedge clk);
    check("R1 status in reset", status_o, '0);
    check("R1 irq in reset", irq_o, '0);
    check("R1 any in reset", {2'b00, irq_any_o, halt_any_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 held trigger counts as rise", status_o, 4'b0001);
    step(4'b0001, 1'b1, 4'b0001);
    check("R9 clear without event", status_o, 4'b0000);
  endtask

  task automatic t_rise;
    cap_mode_i = 2'd1; hold_mode_i = 2'd1;
    step(4'b0011, 1'b0, '0);
    check("R7 only rising bit set", status_o, 4'b0010);
    step(4'b0000, 1'b0, '0);
    check("R4 fall ignored in rising mode", status_o, 4'b0010);
    step(4'b0000, 1'b1, 4'b1111);
    check("R9 clear all", status_o, 4'b0000);
  endtask

  task automatic t_fall;
    cap_mode_i = 2'd2; hold_mode_i = 2'd1;
    step(4'b0100, 1'b0, '0);
    check("R5 rise ignored in falling mode", status_o, 4'b0000);
    step(4'b0000, 1'b0, '0);
    check("R5 fall sets bit", status_o, 4'b0100);
    step(4'b0000, 1'b1, 4'b1111);
  endtask

  task automatic t_both;
    cap_mode_i = 2'd3; hold_mode_i = 2'd1;
    step(4'b1000, 1'b0, '0);
    check("R6 rise captured", status_o, 4'b1000);
    step(4'b1000, 1'b1, 4'b1000);
    check("R6 steady level no event", status_o, 4'b0000);
    step(4'b0000, 1'b0, '0);
    check("R6 fall captured", status_o, 4'b1000);
    step(4'b0000, 1'b1, 4'b1111);
  endtask

  task automatic t_level;
    cap_mode_i = 2'd0; hold_mode_i = 2'd1;
    step(4'b0101, 1'b0, '0);
    check("R3 level sets bits", status_o, 4'b0101);
    step(4'b0000, 1'b0, '0);
    check("R3 held after trigger low", status_o, 4'b0101);
    step(4'b0000, 1'b1, 4'b0001);
    check("R9 partial clear", status_o, 4'b0100);
    step(4'b0000, 1'b1, 4'b1111);
  endtask

  task automatic t_priority;
    cap_mode_i = 2'd1; hold_mode_i = 2'd1;
    step(4'b0001, 1'b0, '0);
    step(4'b0011, 1'b1, 4'b0011);
    check("R10 event beats clear", status_o, 4'b0010);
    step(4'b0000, 1'b1, 4'b1111);
  endtask

  task automatic t_whole;
    cap_mode_i = 2'd1; hold_mode_i = 2'd2;
    step(4'b0000, 1'b1, 4'b1111);
    check("R8 start empty", status_o, 4'b0000);
    step(4'b0110, 1'b0, '0);
    check("R8 whole value loaded", status_o, 4'b0110);
    step(4'b0100, 1'b0, '0);
    check("R8 held without event", status_o, 4'b0110);
    step(4'b0101, 1'b0, '0);
    check("R8 reload replaces field", status_o, 4'b0101);
    step(4'b0101, 1'b1, 4'b0001);
    check("R9 clear in whole mode", status_o, 4'b0100);
  endtask

  task automatic t_follow;
    cap_mode_i = 2'd1; hold_mode_i = 2'd0;
    step(4'b1010, 1'b0, '0);
    check("R2 follows trigger", status_o, 4'b1010);
    step(4'b0011, 1'b1, 4'b1111);
    check("R2 clear ignored", status_o, 4'b0011);
    check("R11 unmasked irq equals status", irq_o, 4'b0011);
  endtask

  task automatic t_qualify;
    mask_i = 4'b0001; halt_qual_i = 4'b0010;
    #1;
    check("R11 mask removes bit", irq_o, 4'b0010);
    check("R12 enable selects bit", halt_o, 4'b0010);
    check("R13 both any high", {2'b00, irq_any_o, halt_any_o}, 4'b0011);
    mask_i = 4'b0011; halt_qual_i = 4'b0000;
    #1;
    check("R11 fully masked", irq_o, 4'b0000);
    check("R12 nothing enabled", halt_o, 4'b0000);
    check("R13 both any low", {2'b00, irq_any_o, halt_any_o}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_priority();
    t_whole();
    t_follow();
    t_qualify();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule